// File: doc/BRIEF.md
# One-Time Fuse Anti-Rollback Counter

This block keeps a firmware version floor in a bank of write-once fuse bits. The bits are burned in order from bit 0 upward, so the stored value is the length of the unbroken run of burned bits starting at bit 0. Boot logic presents the minimum version carried by an image on the check port. One cycle later the block reports whether that image may run, which is the case only when its version is not below the fused floor.

Secure firmware raises the floor by requesting a burn while the secure enable input is high. The sequencer goes from `BS_IDLE` to `BS_PROGRAM` and holds there for a fixed programming time. It then commits the next bit and moves to `BS_REPORT`, where `done` pulses for one cycle, and returns to `BS_IDLE`. The block has three transitions: accept (IDLE→PROGRAM, taken only when a request arrives with enable high and the bank not full), commit (PROGRAM→REPORT, taken when the programming timer reaches zero) and release (REPORT→IDLE, taken unconditionally).

While a burn runs, the block rejects new burn requests and drops checks. Neither reset nor any input clears a burned bit. The bank powers up with every bit unburned.

Top module: `fuse_rollback_ctr`

## Requirements
- R1: Reset returns `busy`, `done` and `chk_valid` to 0 but leaves `fused_val` and every burned bit unchanged. At power-up `fused_val` is 0.
- R2: A check with `chk_ver` greater than or equal to `fused_val` reports `chk_pass` = 1.
- R3: A check with `chk_ver` below `fused_val` reports `chk_pass` = 0.
- R4: `chk_valid` is 1 in the cycle after a check request accepted while idle, and 0 in the cycle after a cycle with no request.
- R5: An accepted burn raises `fused_val` by exactly 1 by burning bit index `fused_val`.
- R6: After the accepting edge, `busy` stays high for exactly BURN_CYCLES+1 (17) sampled cycles. `done` is high only in the last of these cycles, and the new `fused_val` is visible from that cycle on.
- R7: A burn request with `sec_en` = 0 is ignored: `busy` stays 0 and `fused_val` is unchanged.
- R8: A check request made while `busy` is high is dropped, and `chk_valid` stays 0 for it.
- R9: Burn requests made while `busy` is high are ignored. A burn that is already running adds exactly one bit.
- R10: When all FUSE_BITS (32) bits are burned, `exhausted` is 1 and further burn requests are ignored. The highest value, 32, is reached and no higher value exists.
- R11: `gap_fault` (set when a burned bit lies above an unburned one) stays 0 under any sequence of legal burns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; does not touch fuse bits |
| chk_req | input | 1 | Check request strobe |
| chk_ver | input | 6 | Minimum version of the candidate image |
| burn_req | input | 1 | Request to burn the next fuse bit |
| sec_en | input | 1 | Secure-only enable that gates burn requests |
| chk_valid | output | 1 | Check result valid |
| chk_pass | output | 1 | 1 = image allowed, 0 = rollback refused |
| busy | output | 1 | Burn sequence in progress |
| done | output | 1 | One-cycle pulse when a burn completes |
| exhausted | output | 1 | All fuse bits burned |
| gap_fault | output | 1 | Fuse bits do not form a thermometer |
| fused_val | output | 6 | Current fused version floor (0..32) |

## Verification
Checks are made with versions below, equal to and above the floor, at floors 0, 2 and 32. This shows whether the comparison is inclusive and whether its direction is right. Burns are tried with the enable low, with requests repeated during a running burn, and with the bank full. These cases show whether the secure gate, the busy rejection and the exhaustion guard each hold. A reset after several burns shows whether the floor survives reset. Timing a burn cycle by cycle separates an off-by-one programming time from a correct one.

// File: rtl/fuse_ctr_pkg.sv
package fuse_ctr_pkg;
    typedef enum logic [1:0] {
        BS_IDLE    = 2'd0,
        BS_PROGRAM = 2'd1,
        BS_REPORT  = 2'd2
    } burn_state_e;
endpackage

// File: rtl/fuse_bank.sv
module fuse_bank #(
    parameter int FUSE_BITS = 32,
    parameter int VW        = $clog2(FUSE_BITS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 commit,
    input  logic [VW-1:0]        burn_idx,
    output logic [FUSE_BITS-1:0] fuse_bits
);
    // Fuse cells carry no reset: only a commit can change them, and only 0 -> 1.
    logic [FUSE_BITS-1:0] cell_q = '0;

    for (genvar i = 0; i < FUSE_BITS; i++) begin : g_cell
        always_ff @(posedge clk) begin
            if (commit && (burn_idx == VW'(i)))
                cell_q[i] <= 1'b1;
        end
    end

    assign fuse_bits = cell_q;

    p_fuse_keep_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cell_q & $past(cell_q)) == $past(cell_q));

    p_single_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(cell_q ^ $past(cell_q)) <= 1);
endmodule

// File: rtl/fuse_decode.sv
module fuse_decode #(
    parameter int FUSE_BITS = 32,
    parameter int VW        = $clog2(FUSE_BITS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [FUSE_BITS-1:0] fuse_bits,
    output logic [VW-1:0]        level,
    output logic                 full,
    output logic                 gap
);
    always_comb begin
        logic run_ended;
        run_ended = 1'b0;
        level     = '0;
        gap       = 1'b0;
        for (int i = 0; i < FUSE_BITS; i++) begin
            if (fuse_bits[i]) begin
                if (run_ended) gap = 1'b1;
                else           level = level + 1'b1;
            end else begin
                run_ended = 1'b1;
            end
        end
    end

    assign full = (level == VW'(FUSE_BITS));

    p_thermo_r11: assert property (@(posedge clk) disable iff (!rst_n) !gap);
endmodule

// File: rtl/burn_seq.sv
module burn_seq
    import fuse_ctr_pkg::*;
#(
    parameter int BURN_CYCLES = 16,
    parameter int CW          = (BURN_CYCLES > 1) ? $clog2(BURN_CYCLES) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic burn_req,
    input  logic sec_en,
    input  logic full,
    output logic busy,
    output logic done,
    output logic commit
);
    localparam logic [CW-1:0] LOAD = CW'(BURN_CYCLES - 1);

    burn_state_e state_q, state_d;
    logic [CW-1:0] timer_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BS_IDLE:    if (burn_req && sec_en && !full) state_d = BS_PROGRAM;
            BS_PROGRAM: if (timer_q == '0)               state_d = BS_REPORT;
            BS_REPORT:                                   state_d = BS_IDLE;
            default:                                     state_d = BS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                       timer_q <= '0;
        else if (state_q == BS_IDLE)                      timer_q <= LOAD;
        else if (state_q == BS_PROGRAM && timer_q != '0)  timer_q <= timer_q - 1'b1;
    end

    always_comb begin
        busy   = 1'b0;
        done   = 1'b0;
        commit = 1'b0;
        unique case (state_q)
            BS_IDLE:    ;
            BS_PROGRAM: begin
                busy   = 1'b1;
                commit = (timer_q == '0);
            end
            BS_REPORT: begin
                busy = 1'b1;
                done = 1'b1;
            end
            default: ;
        endcase
    end

    p_secure_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BS_IDLE && !sec_en) |=> (state_q == BS_IDLE));

    p_full_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BS_IDLE && full) |=> !busy);

    p_prog_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BS_PROGRAM && timer_q != '0) |=> (state_q == BS_PROGRAM));

    p_one_commit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (!commit && done));
endmodule

// File: rtl/fuse_rollback_ctr.sv
module fuse_rollback_ctr #(
    parameter int FUSE_BITS   = 32,
    parameter int BURN_CYCLES = 16,
    parameter int VW          = $clog2(FUSE_BITS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          chk_req,
    input  logic [VW-1:0] chk_ver,
    input  logic          burn_req,
    input  logic          sec_en,
    output logic          chk_valid,
    output logic          chk_pass,
    output logic          busy,
    output logic          done,
    output logic          exhausted,
    output logic          gap_fault,
    output logic [VW-1:0] fused_val
);
    logic [FUSE_BITS-1:0] fuse_bits;
    logic                 commit;
    logic [VW-1:0]        level;

    fuse_bank #(.FUSE_BITS(FUSE_BITS), .VW(VW)) u_bank (
        .clk(clk), .rst_n(rst_n), .commit(commit),
        .burn_idx(level), .fuse_bits(fuse_bits)
    );

    fuse_decode #(.FUSE_BITS(FUSE_BITS), .VW(VW)) u_dec (
        .clk(clk), .rst_n(rst_n), .fuse_bits(fuse_bits),
        .level(level), .full(exhausted), .gap(gap_fault)
    );

    burn_seq #(.BURN_CYCLES(BURN_CYCLES)) u_seq (
        .clk(clk), .rst_n(rst_n), .burn_req(burn_req), .sec_en(sec_en),
        .full(exhausted), .busy(busy), .done(done), .commit(commit)
    );

    assign fused_val = level;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chk_valid <= 1'b0;
            chk_pass  <= 1'b0;
        end else begin
            chk_valid <= chk_req && !busy;
            chk_pass  <= chk_req && !busy && (chk_ver >= level);
        end
    end

    p_chk_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_req && !busy) |=> chk_valid);

    p_chk_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !chk_valid);

    p_floor_rises_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> (fused_val == $past(fused_val)));
endmodule

// File: tb/sim_fuse_rollback_ctr.sv
module sim_fuse_rollback_ctr;
    localparam int N  = 32;
    localparam int BC = 16;
    localparam int VW = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic chk_req = 1'b0;
    logic [VW-1:0] chk_ver = '0;
    logic burn_req = 1'b0;
    logic sec_en = 1'b0;
    logic chk_valid, chk_pass, busy, done, exhausted, gap_fault;
    logic [VW-1:0] fused_val;

    int n_checks = 0;
    int n_fail = 0;
    int exp_val = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    fuse_rollback_ctr u0 (
        .clk(clk), .rst_n(rst_n), .chk_req(chk_req), .chk_ver(chk_ver),
        .burn_req(burn_req), .sec_en(sec_en), .chk_valid(chk_valid),
        .chk_pass(chk_pass), .busy(busy), .done(done), .exhausted(exhausted),
        .gap_fault(gap_fault), .fused_val(fused_val)
    );

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset_state();
        check(busy == 1'b0, "R1 busy after reset", busy, 0);
        check(done == 1'b0, "R1 done after reset", done, 0);
        check(chk_valid == 1'b0, "R1 chk_valid after reset", chk_valid, 0);
        check(int'(fused_val) == exp_val, "R1 fused_val after reset", fused_val, exp_val);
        check(gap_fault == 1'b0, "R11 gap_fault", gap_fault, 0);
    endtask

    task automatic t_check(input int ver, input bit exp_pass, input string tag);
        @(negedge clk);
        chk_req = 1'b1;
        chk_ver = VW'(ver);
        step();
        check(chk_valid == 1'b1, "R4 chk_valid one cycle after request", chk_valid, 1);
        check(chk_pass == exp_pass, tag, chk_pass, exp_pass);
        @(negedge clk);
        chk_req = 1'b0;
        step();
        check(chk_valid == 1'b0, "R4 chk_valid without request", chk_valid, 0);
    endtask

    task automatic t_burn(input bit sec, input bit expect_accept, input string tag);
        int n_busy;
        int done_at;
        int done_cnt;
        @(negedge clk);
        burn_req = 1'b1;
        sec_en = sec;
        step();
        @(negedge clk);
        burn_req = 1'b0;
        sec_en = 1'b0;
        if (expect_accept) begin
            n_busy = busy ? 1 : 0;
            done_at = 0;
            done_cnt = 0;
            for (int k = 0; k < 40 && busy; k++) begin
                step();
                if (busy) n_busy++;
                if (done) begin
                    done_cnt++;
                    done_at = n_busy;
                    check(int'(fused_val) == exp_val + 1, "R6 new value visible with done", fused_val, exp_val + 1);
                end
            end
            exp_val++;
            check(n_busy == BC + 1, "R6 busy length", n_busy, BC + 1);
            check(done_cnt == 1 && done_at == BC + 1, "R6 done in last busy cycle", done_at, BC + 1);
            check(int'(fused_val) == exp_val, tag, fused_val, exp_val);
        end else begin
            check(busy == 1'b0, tag, busy, 0);
            repeat (3) step();
            check(int'(fused_val) == exp_val, tag, fused_val, exp_val);
        end
        check(gap_fault == 1'b0, "R11 gap_fault after burn", gap_fault, 0);
    endtask

    task automatic t_busy_interference();
        int valid_seen;
        valid_seen = 0;
        @(negedge clk);
        burn_req = 1'b1;
        sec_en = 1'b1;
        step();
        check(busy == 1'b1, "R9 burn accepted", busy, 1);
        for (int k = 0; k < 40 && busy; k++) begin
            @(negedge clk);
            chk_req = 1'b1;
            chk_ver = '0;
            burn_req = 1'b1;
            step();
            if (chk_valid && busy) valid_seen++;
        end
        @(negedge clk);
        chk_req = 1'b0;
        burn_req = 1'b0;
        sec_en = 1'b0;
        exp_val++;
        step();
        check(valid_seen == 0, "R8 checks dropped while busy", valid_seen, 0);
        check(int'(fused_val) == exp_val, "R9 one bit per running burn", fused_val, exp_val);
        check(busy == 1'b0, "R9 no second burn queued", busy, 0);
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        t_reset_state();
        t_check(0, 1'b1, "R2 equal at floor 0");
        t_check(5, 1'b1, "R2 above floor 0");
        t_burn(1'b0, 1'b0, "R7 burn ignored without sec_en");
        t_burn(1'b1, 1'b1, "R5 first burn");
        t_burn(1'b1, 1'b1, "R5 second burn");
        t_check(1, 1'b0, "R3 below floor 2");
        t_check(2, 1'b1, "R2 equal floor 2");
        t_check(3, 1'b1, "R2 above floor 2");
        t_check(0, 1'b0, "R3 zero below floor 2");
        t_busy_interference();
        @(negedge clk);
        rst_n = 1'b0;
        step();
        @(negedge clk);
        rst_n = 1'b1;
        step();
        t_reset_state();
        while (exp_val < N) t_burn(1'b1, 1'b1, "R5 burn toward full");
        check(exhausted == 1'b1, "R10 exhausted at full", exhausted, 1);
        check(int'(fused_val) == N, "R10 highest value", fused_val, N);
        t_burn(1'b1, 1'b0, "R10 burn ignored when full");
        t_check(N - 1, 1'b0, "R3 below full floor");
        t_check(N, 1'b1, "R2 equal full floor");
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(5 * 20000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule